// File: doc/BRIEF.md
# Top-Relative Register Stack File

This block holds eight floating-point operands in a circular register file whose entries are named by their distance from a moving top pointer. Slot st0 is always the current top. Slots st1 to st7 are the next entries down the stack. A numeric unit can use the file as a stack: it pushes operands, computes, and pops results. It can also use it as an accumulator (st0) plus seven registers that it reads and writes directly by relative index.

Each physical entry has a full/empty tag. A push that would land on a full entry is refused and reported as an overflow. Popping, exchanging or reading an empty entry is reported as an underflow. The stored words are opaque, with a width set by a parameter. One operation is accepted per cycle. An independent read port runs alongside it and sees the state before that cycle's operation.

Top module: `relstack_rf`

## Requirements
- R1: After reset the top pointer is 0, every entry is empty, and both flags are low.
- R2: Relative index i selects physical entry (top + i) mod 8. A read with rd_en_i high returns st(rd_idx_i) on rd_data_o one cycle later.
- R3: Push (op code 1) onto an empty target decrements top modulo 8 (0 goes to 7), stores wdata_i in the new st0 and marks it full.
- R4: Push onto a full target sets ovf_o for one cycle and leaves the top pointer and all contents unchanged.
- R5: Pop (op code 2) of a full st0 marks that entry empty and increments top modulo 8.
- R6: Pop of an empty st0, or a read of an empty entry, sets unf_o in the following cycle. A failed pop changes no state.
- R7: Write (op code 3) stores wdata_i in st(idx_i) and marks that entry full, whatever its previous tag.
- R8: Exchange (op code 4) swaps st0 and st(idx_i) in one cycle when both are full.
- R9: Exchange with either operand empty sets unf_o and changes nothing.
- R10: Write-and-pop (op code 5) writes st(idx_i), where idx_i is counted before the pop, then pops. If idx_i is 0 the written value is discarded with the popped entry. If st0 is empty it acts like R6.
- R11: Op codes 0, 6 and 7 change nothing. The read port always sees the state before the same cycle's operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge inside the block |
| op_i | input | 3 | Operation code |
| idx_i | input | 3 | Relative index for write, exchange and write-and-pop |
| wdata_i | input | WORD_W | Word for push, write and write-and-pop |
| rd_en_i | input | 1 | Read strobe |
| rd_idx_i | input | 3 | Relative index for the read port |
| rd_data_o | output | WORD_W | Registered read data |
| top_o | output | 3 | Current top pointer |
| ovf_o | output | 1 | Overflow flag for the previous cycle |
| unf_o | output | 1 | Underflow flag for the previous cycle |

## Verification
The bench builds the block with eight entries and 16-bit words, which keeps the stored values easy to tell apart. Eight entries are few enough that a single run can fill the whole stack to reach overflow and can drain it back to reach underflow. The same run wraps the top pointer both ways. The run also leaves empty entries sitting among full ones, so the exchange and write-and-pop checks meet mixed tags.

// File: rtl/relstack_pkg.sv
package relstack_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_WRITE = 3'd3,
    OP_XCHG  = 3'd4,
    OP_WRPOP = 3'd5
  } rs_op_e;
endpackage

// File: rtl/relstack_ctrl.sv
module relstack_ctrl
  import relstack_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op_i,
  input  logic [PTR_W-1:0] idx_i,
  input  logic [DEPTH-1:0] full_i,
  input  logic             rd_unf_i,
  output logic [PTR_W-1:0] top_o,
  output logic             wa_en_o,
  output logic [PTR_W-1:0] wa_addr_o,
  output logic             wb_en_o,
  output logic [PTR_W-1:0] wb_addr_o,
  output logic             swap_o,
  output logic [DEPTH-1:0] set_o,
  output logic [DEPTH-1:0] clr_o,
  output logic             ovf_o,
  output logic             unf_o
);
  logic [PTR_W-1:0] top_q, top_n, p_push, p_idx, p_inc;
  logic             ovf_q, unf_q, ovf_n, unf_op;
  logic             top_en;
  rs_op_e           op;

  assign op     = rs_op_e'(op_i);
  assign p_push = top_q - PTR_W'(1);
  assign p_inc  = top_q + PTR_W'(1);
  assign p_idx  = top_q + idx_i;

  always_comb begin
    top_n     = top_q;
    top_en    = 1'b0;
    wa_en_o   = 1'b0;
    wa_addr_o = p_idx;
    wb_en_o   = 1'b0;
    wb_addr_o = p_idx;
    swap_o    = 1'b0;
    set_o     = '0;
    clr_o     = '0;
    ovf_n     = 1'b0;
    unf_op    = 1'b0;
    case (op)
      OP_PUSH: begin
        if (full_i[p_push]) begin
          ovf_n = 1'b1;
        end else begin
          top_n          = p_push;
          top_en         = 1'b1;
          wa_en_o        = 1'b1;
          wa_addr_o      = p_push;
          set_o[p_push]  = 1'b1;
        end
      end
      OP_POP: begin
        if (!full_i[top_q]) begin
          unf_op = 1'b1;
        end else begin
          clr_o[top_q] = 1'b1;
          top_n        = p_inc;
          top_en       = 1'b1;
        end
      end
      OP_WRITE: begin
        wa_en_o      = 1'b1;
        set_o[p_idx] = 1'b1;
      end
      OP_XCHG: begin
        if (!full_i[top_q] || !full_i[p_idx]) begin
          unf_op = 1'b1;
        end else begin
          wa_en_o   = 1'b1;
          wa_addr_o = top_q;
          wb_en_o   = 1'b1;
          swap_o    = 1'b1;
        end
      end
      OP_WRPOP: begin
        if (!full_i[top_q]) begin
          unf_op = 1'b1;
        end else begin
          wa_en_o      = 1'b1;
          set_o[p_idx] = 1'b1;
          clr_o[top_q] = 1'b1;
          top_n        = p_inc;
          top_en       = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (top_en) top_q <= top_n;
      ovf_q <= ovf_n;
      unf_q <= unf_op | rd_unf_i;
    end
  end

  assign top_o = top_q;
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

  assert_push_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH && !full_i[p_push]) |=> (top_q == $past(p_push)) && !ovf_q);
  assert_no_overflow_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH && full_i[p_push]) |=> ovf_q && $stable(top_q));
  assert_pop_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_POP && full_i[top_q]) |=> (top_q == $past(p_inc)));
  assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_POP && !full_i[top_q]) |=> unf_q && $stable(top_q));
  assert_xchg_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_XCHG && (!full_i[top_q] || !full_i[p_idx])) |=> unf_q && $stable(top_q));
endmodule

// File: rtl/relstack_tags.sv
module relstack_tags #(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] set_i,
  input  logic [DEPTH-1:0] clr_i,
  output logic [DEPTH-1:0] full_o
);
  logic [DEPTH-1:0] tag_q, tag_n;

  always_comb tag_n = (tag_q | set_i) & ~clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag_q <= '0;
    else        tag_q <= tag_n;
  end

  assign full_o = tag_q;

  assert_clear_only_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i & ~tag_q) == '0);
endmodule

// File: rtl/relstack_store.sv
module relstack_store #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 80,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    wa_en_i,
  input  logic [PTR_W-1:0]        wa_addr_i,
  input  logic [WORD_W-1:0]       wa_data_i,
  input  logic                    wb_en_i,
  input  logic [PTR_W-1:0]        wb_addr_i,
  input  logic [WORD_W-1:0]       wb_data_i,
  output logic [DEPTH*WORD_W-1:0] ent_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [WORD_W-1:0] word_q;
    logic              hit_a, hit_b;
    assign hit_a = wa_en_i && (wa_addr_i == PTR_W'(g));
    assign hit_b = wb_en_i && (wb_addr_i == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (hit_a)      word_q <= wa_data_i;
      else if (hit_b) word_q <= wb_data_i;
    end
    assign ent_o[g*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/relstack_rf.sv
module relstack_rf #(
  parameter int WORD_W = 80,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic [PTR_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              rd_en_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [PTR_W-1:0]  top_o,
  output logic              ovf_o,
  output logic              unf_o
);
  logic                    rst_meta, rst_sync;
  logic [PTR_W-1:0]        top;
  logic [DEPTH-1:0]        full, set_m, clr_m;
  logic                    wa_en, wb_en, swap;
  logic [PTR_W-1:0]        wa_addr, wb_addr, rd_phys;
  logic [WORD_W-1:0]       wa_data, wb_data, rd_word, rd_q;
  logic [DEPTH*WORD_W-1:0] ent;
  logic                    rd_unf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  relstack_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_sync), .op_i(op_i), .idx_i(idx_i), .full_i(full),
    .rd_unf_i(rd_unf), .top_o(top), .wa_en_o(wa_en), .wa_addr_o(wa_addr),
    .wb_en_o(wb_en), .wb_addr_o(wb_addr), .swap_o(swap), .set_o(set_m),
    .clr_o(clr_m), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  relstack_tags #(.DEPTH(DEPTH)) u_tags (
    .clk(clk), .rst_n(rst_sync), .set_i(set_m), .clr_i(clr_m), .full_o(full)
  );

  assign wa_data = swap ? ent[wb_addr*WORD_W +: WORD_W] : wdata_i;
  assign wb_data = ent[wa_addr*WORD_W +: WORD_W];

  relstack_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk(clk), .wa_en_i(wa_en), .wa_addr_i(wa_addr), .wa_data_i(wa_data),
    .wb_en_i(wb_en), .wb_addr_i(wb_addr), .wb_data_i(wb_data), .ent_o(ent)
  );

  assign rd_phys = top + rd_idx_i;
  assign rd_word = ent[rd_phys*WORD_W +: WORD_W];
  assign rd_unf  = rd_en_i & ~full[rd_phys];

  always_ff @(posedge clk) begin
    if (rd_en_i) rd_q <= rd_word;
  end

  assign rd_data_o = rd_q;
  assign top_o     = top;

  assert_reset_empty_R1: assert property (@(posedge clk)
    !rst_sync |=> (full == '0) && (top == '0));
  assert_read_empty_R6: assert property (@(posedge clk) disable iff (!rst_sync)
    (rd_en_i && !full[rd_phys]) |=> unf_o);
  assert_no_overflow_full_R4: assert property (@(posedge clk) disable iff (!rst_sync)
    ovf_o |-> $stable(full));
endmodule

// File: tb/relstack_rf_tb.sv
module relstack_rf_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    op_i, idx_i, rd_idx_i;
  logic [WW-1:0] wdata_i, rd_data_o;
  logic          rd_en_i;
  logic [2:0]    top_o;
  logic          ovf_o, unf_o;
  int            checks = 0;
  int            errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  relstack_rf #(.WORD_W(WW), .DEPTH(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .idx_i(idx_i), .wdata_i(wdata_i),
    .rd_en_i(rd_en_i), .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o),
    .top_o(top_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [2:0] idx, input logic [WW-1:0] d,
                      input logic ren, input logic [2:0] ridx);
    op_i = op; idx_i = idx; wdata_i = d; rd_en_i = ren; rd_idx_i = ridx;
    @(negedge clk);
    op_i = 3'd0; idx_i = '0; wdata_i = '0; rd_en_i = 1'b0; rd_idx_i = '0;
  endtask

  task automatic rd(input string req, input logic [2:0] ridx, input logic [WW-1:0] exp);
    step(3'd0, 3'd0, '0, 1'b1, ridx);
    chk(req, {16'd0, rd_data_o}, {16'd0, exp});
    chk(req, {31'd0, unf_o}, 32'd0);
  endtask

  task automatic rd_empty(input string req, input logic [2:0] ridx);
    step(3'd0, 3'd0, '0, 1'b1, ridx);
    chk(req, {31'd0, unf_o}, 32'd1);
  endtask

  task automatic t_reset;
    chk("R1 top", {29'd0, top_o}, 32'd0);
    chk("R1 ovf", {31'd0, ovf_o}, 32'd0);
    chk("R1 unf", {31'd0, unf_o}, 32'd0);
    rd_empty("R1 st0 empty", 3'd0);
  endtask

  task automatic t_push_pop;
    step(3'd1, 3'd0, 16'h1111, 1'b0, 3'd0);
    chk("R3 wrap top", {29'd0, top_o}, 32'd7);
    chk("R3 no ovf", {31'd0, ovf_o}, 32'd0);
    step(3'd1, 3'd0, 16'h2222, 1'b0, 3'd0);
    chk("R3 top", {29'd0, top_o}, 32'd6);
    rd("R3 st0", 3'd0, 16'h2222);
    rd("R2 st1", 3'd1, 16'h1111);
    step(3'd2, 3'd0, '0, 1'b0, 3'd0);
    chk("R5 top", {29'd0, top_o}, 32'd7);
    rd("R5 st0", 3'd0, 16'h1111);
    rd_empty("R5 popped entry empty", 3'd7);
  endtask

  task automatic t_fill;
    for (int k = 1; k <= 7; k++) step(3'd1, 3'd0, 16'h3000 + 16'(k), 1'b0, 3'd0);
    chk("R3 full top", {29'd0, top_o}, 32'd0);
    step(3'd1, 3'd0, 16'h9999, 1'b0, 3'd0);
    chk("R4 ovf", {31'd0, ovf_o}, 32'd1);
    chk("R4 top held", {29'd0, top_o}, 32'd0);
    rd("R4 st0 kept", 3'd0, 16'h3007);
    rd("R4 st7 kept", 3'd7, 16'h1111);
    chk("R4 ovf one cycle", {31'd0, ovf_o}, 32'd0);
  endtask

  task automatic t_write_xchg;
    step(3'd3, 3'd3, 16'h4444, 1'b0, 3'd0);
    rd("R7 st3", 3'd3, 16'h4444);
    step(3'd4, 3'd3, '0, 1'b0, 3'd0);
    chk("R8 no unf", {31'd0, unf_o}, 32'd0);
    rd("R8 st0", 3'd0, 16'h4444);
    rd("R8 st3", 3'd3, 16'h3007);
  endtask

  task automatic t_concurrent;
    step(3'd2, 3'd0, '0, 1'b1, 3'd0);
    chk("R11 read sees pre-pop", {16'd0, rd_data_o}, 32'h4444);
    chk("R5 top", {29'd0, top_o}, 32'd1);
    rd("R5 new st0", 3'd0, 16'h3006);
  endtask

  task automatic t_wrpop;
    step(3'd5, 3'd2, 16'h5555, 1'b0, 3'd0);
    chk("R10 top", {29'd0, top_o}, 32'd2);
    rd("R10 st1", 3'd1, 16'h5555);
    rd("R10 st0", 3'd0, 16'h3005);
    step(3'd5, 3'd0, 16'h6666, 1'b0, 3'd0);
    chk("R10 top idx0", {29'd0, top_o}, 32'd3);
    rd("R10 st0 idx0", 3'd0, 16'h5555);
    rd_empty("R10 discarded entry empty", 3'd7);
  endtask

  task automatic t_nop;
    step(3'd6, 3'd1, 16'hDEAD, 1'b0, 3'd0);
    step(3'd7, 3'd2, 16'hBEEF, 1'b0, 3'd0);
    chk("R11 top", {29'd0, top_o}, 32'd3);
    chk("R11 flags", {30'd0, ovf_o, unf_o}, 32'd0);
    rd("R11 st0", 3'd0, 16'h5555);
    rd("R11 st1", 3'd1, 16'h3003);
  endtask

  task automatic t_drain;
    for (int k = 0; k < 5; k++) step(3'd2, 3'd0, '0, 1'b0, 3'd0);
    chk("R5 drained top", {29'd0, top_o}, 32'd0);
    step(3'd2, 3'd0, '0, 1'b0, 3'd0);
    chk("R6 unf", {31'd0, unf_o}, 32'd1);
    chk("R6 top held", {29'd0, top_o}, 32'd0);
    step(3'd5, 3'd1, 16'h1234, 1'b0, 3'd0);
    chk("R10 empty unf", {31'd0, unf_o}, 32'd1);
    rd_empty("R10 nothing written", 3'd1);
  endtask

  task automatic t_xchg_empty;
    step(3'd1, 3'd0, 16'h7777, 1'b0, 3'd0);
    step(3'd4, 3'd2, '0, 1'b0, 3'd0);
    chk("R9 unf", {31'd0, unf_o}, 32'd1);
    chk("R9 top", {29'd0, top_o}, 32'd7);
    rd("R9 st0 kept", 3'd0, 16'h7777);
    rd_empty("R9 st2 still empty", 3'd2);
  endtask

  initial begin
    rst_n = 1'b0; op_i = '0; idx_i = '0; wdata_i = '0; rd_en_i = 1'b0; rd_idx_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_push_pop();
    t_fill();
    t_write_xchg();
    t_concurrent();
    t_wrpop();
    t_nop();
    t_drain();
    t_xchg_empty();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule